// File: doc/BRIEF.md
# Indirect Configuration Byte Bridge

This block sits on a simple single-cycle register bus and presents one 32-bit control word at byte offset 0x00 of its window. Behind that word lies a bank of 32 configuration registers, each 8 bits wide. The bank cannot be addressed from the bus directly. A host reaches it by packing a register index, a data byte and two control bits into the control word.

One control bit releases the bank from reset. While it is low, every byte in the bank is held at zero. The other control bit commits the data byte into the selected register, and only its rising edge does so. A host therefore writes the word with the bit set and then writes it again with the bit clear. The bank register chosen by the index field is returned in the low byte of the same word on every read. The other host fields read back exactly as they were last written.

Top module: `idx_cfg_bridge`

## Requirements
- R1: A synchronous active-high `rst` clears the control word and every bank register, and forces `bus_rdata` to 0x00000000.
- R2: The control word lives only at bus byte address 0x0. A bus write to any other address changes nothing, and a bus read of any other address returns 0x00000000.
- R3: Control word layout: bit 28 = bank release, bit 24 = commit bit, bits 20:16 = register index, bits 15:8 = data byte, bits 7:0 = read-back byte. Bits 28, 24, 20:16 and 15:8 read back as last written. Bits 31:29, 27:25 and 23:21 always read 0, and a value written into bits 7:0 is discarded.
- R4: A bus write to the control word in which bit 24 goes from 0 (stored) to 1 (written) stores the written data byte into the register at the written index. This happens only if the stored bank release bit is 1 and the written word keeps bit 28 at 1.
- R5: Writing the word again while the commit bit stays 1, even with a new index or data byte, stores nothing. Clearing the commit bit stores nothing. A release that rises in the same write as the commit bit, or in a write where the commit bit is already 1, stores nothing.
- R6: In every cycle that follows a write leaving the release bit at 0, all 32 registers read 0x00 and commit edges are ignored. Values stored before the release bit was cleared are lost.
- R7: A bus read of the control word returns, in bits 7:0, the register selected by the index that was stored before that read. No extra handshake is needed after an index change.
- R8: The 32 registers are independent. A commit changes only the register at the written index.
- R9: `bus_rdata` is registered. It updates only in the cycle after a bus read and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Bus write enable, one cycle per access |
| bus_rd | input | 1 | Bus read enable, one cycle per access |
| bus_addr | input | 4 | Bus byte address inside the block window |
| bus_wdata | input | 32 | Bus write data |
| bus_rdata | output | 32 | Registered bus read data |

## Verification
The bench goes after the commit edge. It holds the commit bit high across a write that carries fresh data and checks that the first byte survives; a design that stored on level would overwrite it. It also raises the commit bit while the bank is held, and then releases the bank while the bit is already high; a design that missed either gate would leave a nonzero byte. It clears the release bit after storing bytes and checks that they read back as zero, and it writes off-window and into the unused bits to catch a decoder that aliases addresses or stores undefined bits.

// File: rtl/idx_cfg_pkg.sv
package idx_cfg_pkg;
  localparam int HOST_W   = 32;
  localparam int CFG_AW   = 5;
  localparam int CFG_DW   = 8;
  localparam int RUN_BIT  = 28;
  localparam int CMT_BIT  = 24;
  localparam int IDX_LSB  = 16;
  localparam int DAT_LSB  = 8;
  localparam int RBK_LSB  = 0;
  localparam int NUM_REGS = 1 << CFG_AW;
endpackage

// File: rtl/ctl_word_reg.sv
module ctl_word_reg
  import idx_cfg_pkg::*;
#(
  parameter int AW = CFG_AW,
  parameter int DW = CFG_DW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hit_wr,
  input  logic [HOST_W-1:0] wdata,
  output logic              run_q,
  output logic              run_d,
  output logic              cmt_q,
  output logic              cmt_d,
  output logic [AW-1:0]     idx_q,
  output logic [AW-1:0]     idx_d,
  output logic [DW-1:0]     dat_q,
  output logic [DW-1:0]     dat_d
);
  // next-state view of each field, taken from the bus on a hit
  always_comb begin
    run_d = run_q;
    cmt_d = cmt_q;
    idx_d = idx_q;
    dat_d = dat_q;
    if (hit_wr) begin
      run_d = wdata[RUN_BIT];
      cmt_d = wdata[CMT_BIT];
      idx_d = wdata[IDX_LSB +: AW];
      dat_d = wdata[DAT_LSB +: DW];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0;
      cmt_q <= 1'b0;
      idx_q <= '0;
      dat_q <= '0;
    end else begin
      run_q <= run_d;
      cmt_q <= cmt_d;
      idx_q <= idx_d;
      dat_q <= dat_d;
    end
  end
endmodule

// File: rtl/commit_detect.sv
module commit_detect (
  input  logic hit_wr,
  input  logic run_q,
  input  logic run_d,
  input  logic cmt_q,
  input  logic cmt_d,
  output logic commit
);
  // rising edge of the commit bit, only with the bank already released
  always_comb begin
    commit = hit_wr && cmt_d && !cmt_q && run_q && run_d;
  end
endmodule

// File: rtl/cfg_bank.sv
module cfg_bank #(
  parameter int AW = 5,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          clr,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (clr) begin
        mem[g] <= '0;
      end else if (we && (waddr == AW'(g))) begin
        mem[g] <= wdata;
      end
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/idx_cfg_bridge.sv
module idx_cfg_bridge
  import idx_cfg_pkg::*;
#(
  parameter int BUS_AW = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [HOST_W-1:0] bus_wdata,
  output logic [HOST_W-1:0] bus_rdata
);
  logic              hit;
  logic              hit_wr;
  logic              run_q, run_d, cmt_q, cmt_d;
  logic [CFG_AW-1:0] idx_q, idx_d;
  logic [CFG_DW-1:0] dat_q, dat_d;
  logic              commit;
  logic              bank_clr;
  logic [CFG_DW-1:0] bank_rd;
  logic [HOST_W-1:0] word;

  assign hit    = (bus_addr == '0);
  assign hit_wr = bus_wr && hit;

  ctl_word_reg #(.AW(CFG_AW), .DW(CFG_DW)) u_ctl (
    .clk(clk), .rst(rst), .hit_wr(hit_wr), .wdata(bus_wdata),
    .run_q(run_q), .run_d(run_d), .cmt_q(cmt_q), .cmt_d(cmt_d),
    .idx_q(idx_q), .idx_d(idx_d), .dat_q(dat_q), .dat_d(dat_d)
  );

  commit_detect u_cmt (
    .hit_wr(hit_wr), .run_q(run_q), .run_d(run_d),
    .cmt_q(cmt_q), .cmt_d(cmt_d), .commit(commit)
  );

  // bank follows the release bit at the same edge the word takes it
  assign bank_clr = rst || !run_d;

  cfg_bank #(.AW(CFG_AW), .DW(CFG_DW)) u_bank (
    .clk(clk), .clr(bank_clr), .we(commit), .waddr(idx_d),
    .wdata(dat_d), .raddr(idx_q), .rdata(bank_rd)
  );

  always_comb begin
    word = '0;
    word[RUN_BIT]              = run_q;
    word[CMT_BIT]              = cmt_q;
    word[IDX_LSB +: CFG_AW]    = idx_q;
    word[DAT_LSB +: CFG_DW]    = dat_q;
    word[RBK_LSB +: CFG_DW]    = bank_rd;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      bus_rdata <= hit ? word : '0;
    end
  end
endmodule

// File: rtl/idx_cfg_bridge_chk.sv
module idx_cfg_bridge_chk #(
  parameter int BUS_AW = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [BUS_AW-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic              run_q,
  input logic              commit,
  input logic [7:0]        bank_rd
);
  localparam logic [31:0] DEFINED = 32'h111F_FFFF;

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (bus_rdata == 32'h0)); // R1
  AST_OFF_WINDOW_READ: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr != '0) |=> (bus_rdata == 32'h0)); // R2
  AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (rst)
    ((bus_rdata & ~DEFINED) == 32'h0)); // R3
  AST_COMMIT_STORES: assert property (@(posedge clk) disable iff (rst)
    commit |=> (bank_rd == $past(bus_wdata[15:8]))); // R4
  AST_ONE_COMMIT: assert property (@(posedge clk) disable iff (rst)
    commit |=> !commit); // R5
  AST_HELD_ZERO: assert property (@(posedge clk) disable iff (rst)
    !run_q |-> (bank_rd == 8'h0)); // R6
  AST_READ_TRACKS: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == '0) |=> (bus_rdata[7:0] == $past(bank_rd))); // R7
  AST_BANK_STABLE: assert property (@(posedge clk) disable iff (rst)
    (run_q && !commit && !bus_wr) |=> $stable(bank_rd)); // R8
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata)); // R9
endmodule

bind idx_cfg_bridge idx_cfg_bridge_chk #(.BUS_AW(BUS_AW)) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .run_q(run_q), .commit(commit), .bank_rd(bank_rd)
);

// File: tb/tb_idx_cfg_bridge.sv
module tb_idx_cfg_bridge;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 31;

  typedef struct packed {
    logic        rd;
    logic [3:0]  a;
    logic [31:0] d;
    logic [31:0] e;
    logic [3:0]  r;
  } vec_t;

  // rd=1: read address a, expect e; rd=0: write d to address a
  localparam vec_t VT [NV] = '{
    '{1'b0, 4'h0, 32'h1000_0000, 32'h0, 4'd0},
    '{1'b1, 4'h0, 32'h0, 32'h1000_0000, 4'd3},   // R3 release reads back
    '{1'b0, 4'h0, 32'h1003_5A00, 32'h0, 4'd0},
    '{1'b0, 4'h0, 32'h1103_5A00, 32'h0, 4'd0},
    '{1'b1, 4'h0, 32'h0, 32'h1103_5A5A, 4'd4},   // R4 rising edge stores
    '{1'b0, 4'h0, 32'h1103_A500, 32'h0, 4'd0},
    '{1'b1, 4'h0, 32'h0, 32'h1103_A55A, 4'd5},   // R5 held high, no store
    '{1'b0, 4'h0, 32'h1003_A500, 32'h0, 4'd0},
    '{1'b1, 4'h0, 32'h0, 32'h1003_A55A, 4'd5},   // R5 clear, no store
    '{1'b0, 4'h0, 32'h101F_C300, 32'h0, 4'd0},
    '{1'b0, 4'h0, 32'h111F_C300, 32'h0, 4'd0},
    '{1'b0, 4'h0, 32'h101F_C300, 32'h0, 4'd0},
    '{1'b1, 4'h0, 32'h0, 32'h101F_C3C3, 4'd8},   // R8 top index
    '{1'b0, 4'h0, 32'h1003_0000, 32'h0, 4'd0},
    '{1'b1, 4'h0, 32'h0, 32'h1003_005A, 4'd7},   // R7 index change seen
    '{1'b0, 4'h4, 32'h1107_7700, 32'h0, 4'd0},
    '{1'b1, 4'h0, 32'h0, 32'h1003_005A, 4'd2},   // R2 off-window write ignored
    '{1'b1, 4'h4, 32'h0, 32'h0000_0000, 4'd2},   // R2 off-window read
    '{1'b0, 4'h0, 32'h1000_0000, 32'h0, 4'd0},
    '{1'b1, 4'h0, 32'h0, 32'h1000_0000, 4'd8},   // R8 index 0 untouched
    '{1'b0, 4'h0, 32'h0003_0000, 32'h0, 4'd0},
    '{1'b1, 4'h0, 32'h0, 32'h0003_0000, 4'd6},   // R6 wiped by hold
    '{1'b0, 4'h0, 32'h0103_7700, 32'h0, 4'd0},
    '{1'b1, 4'h0, 32'h0, 32'h0103_7700, 4'd6},   // R6 commit while held
    '{1'b0, 4'h0, 32'h1103_7700, 32'h0, 4'd0},
    '{1'b1, 4'h0, 32'h0, 32'h1103_7700, 4'd5},   // R5 release with bit high
    '{1'b0, 4'h0, 32'h1003_7700, 32'h0, 4'd0},
    '{1'b0, 4'h0, 32'h1103_7700, 32'h0, 4'd0},
    '{1'b1, 4'h0, 32'h0, 32'h1103_7777, 4'd4},   // R4 store after clean edge
    '{1'b0, 4'h0, 32'hFFFF_77FF, 32'h0, 4'd0},
    '{1'b1, 4'h0, 32'h0, 32'h111F_7700, 4'd3}    // R3 unused bits dropped
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;

  int n_chk = 0;
  int n_bad = 0;
  logic done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  idx_cfg_bridge dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %08h expected %08h", req, got, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    v = bus_rdata;
  endtask

  initial begin
    logic [31:0] v;
    logic [31:0] held;
    repeat (3) @(negedge clk);
    check("R1 reset value", bus_rdata, 32'h0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      if (VT[i].rd) begin
        bus_read(VT[i].a, v);
        check($sformatf("R%0d vector %0d", VT[i].r, i), v, VT[i].e);
      end else begin
        bus_write(VT[i].a, VT[i].d);
      end
    end

    // R9: output holds through idle cycles
    held = bus_rdata;
    repeat (4) @(negedge clk);
    check("R9 hold while idle", bus_rdata, held);
    bus_write(4'h0, 32'h1003_0000);
    check("R9 hold across write", bus_rdata, held);

    // R1: reset mid-run clears word, output and bank
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 output after reset", bus_rdata, 32'h0);
    rst = 1'b0;
    bus_read(4'h0, v);
    check("R1 word after reset", v, 32'h0);
    bus_write(4'h0, 32'h1003_0000);
    bus_read(4'h0, v);
    check("R1 bank after reset", v, 32'h1003_0000);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end
endmodule